// File: doc/BRIEF.md
# Wired interrupt source trigger and pending bank

This block holds the per-source interrupt state for a small set of wired interrupt lines, numbered from 1 up to `NUM_SRC`. Each source has a configuration word, a pending flag, an enable flag and a captured copy of its input line. On every clock the block compares each line against its stored level and its configured trigger mode, and sets pending on an edge or an active level. Software can set or clear pending and enable flags through a 32-bit register port. It can write whole 32-bit bitmap words or name a single source by its number. Each of these writes is filtered by the source's mode and by the domain's delivery mode.

The block drives one output per source that is high when that source is both pending and enabled. A priority selector or a message generator downstream consumes this vector. The register port uses word addresses. Bits [9:6] select a region and bits [5:0] select an index. Reads are combinational and have no side effects. Unmapped reads return zero. The input lines must already be synchronous to `clk_i`.

Top module: `irq_src_bank`

## Requirements
- R1: After reset every configuration word, pending flag, enable flag and captured input is zero, so `ip_en_o` is all zero and every region reads zero.
- R2: The configuration word of source s is at region 0, index s-1. A write with bit 10 (delegate) clear stores only bits [2:0] (the mode). A write with bit 10 set stores bit 10 and bits [9:0] (child index). Reads return the stored 11 bits, zero-extended.
- R3: A configuration write that stores zero, or that stores the delegate flag, clears that source's pending and enable flags at the same clock edge. Any other configuration write leaves them alone.
- R4: When `HAS_CHILD` is 0, a configuration write with bit 10 set stores zero.
- R5: In rising mode (4), pending is set when the line is high, the captured level is low and the source is not pending. Falling mode (5) is the mirror: line low and captured level high.
- R6: In level-high mode (6), pending is set whenever the line is high. In level-low mode (7), pending is set whenever the line is low.
- R7: Every clock, a non-delegated source captures its line level after the pending decision. A delegated source keeps its captured level. Region 2 reads return the captured levels.
- R8: Software pending set and clear are ignored for inactive (mode 0) or delegated sources. For level sources both are ignored when `msg_mode_i` is 0. When `msg_mode_i` is 1, a set is applied and a clear is ignored. A software clear overrides a hardware set in the same cycle.
- R9: Software enable set and clear are ignored for inactive or delegated sources.
- R10: In the bitmap regions, index w bit i maps to source 32w+i. Region 1 is set-pending (reads pending), region 2 is clear-pending (reads captured input), region 3 is set-enable (reads enable) and region 4 is clear-enable (reads zero). Source 0 always reads 0, and its bit has no effect when written.
- R11: In region 5, indices 0 to 3 set pending, clear pending, set enable and clear enable for the source whose number is the written data. A number of 0 or greater than `NUM_SRC` has no effect.
- R12: `ip_en_o[s]` is high exactly when source s is both pending and enabled. It follows the state registers with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| msg_mode_i | input | 1 | 1 = message-signalled delivery, 0 = direct delivery |
| irq_i | input | NUM_SRC | Raw interrupt lines, bit s for source s |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 10 | Word address: region [9:6], index [5:0] |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Combinational read data for reg_addr_i |
| ip_en_o | output | NUM_SRC | Per-source pending-and-enabled flag |

## Verification
The bound checker watches several behaviours on every cycle for every source:
- the edge rule that sets pending on a rising line;
- the captured level following the line while the source is not delegated;
- level-mode pending surviving every write except a configuration write;
- the enable flag staying still while a source is inactive or delegated;
- pending and enable being cleared by a zeroing or delegating configuration write.

Other behaviours can only be shown by the bench's scenarios, which compare reads and outputs with a model. These are:
- the address decoding and field masking;
- the source-0 and out-of-range number cases;
- the forced-zero delegate flag without children;
- the delivery-mode difference for software sets.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;
  localparam int unsigned REG_AW = 10;
  localparam int unsigned IDX_W  = 6;

  localparam logic [3:0] RG_CFG   = 4'd0;
  localparam logic [3:0] RG_SETIP = 4'd1;
  localparam logic [3:0] RG_CLRIP = 4'd2;
  localparam logic [3:0] RG_SETIE = 4'd3;
  localparam logic [3:0] RG_CLRIE = 4'd4;
  localparam logic [3:0] RG_NUM   = 4'd5;

  localparam logic [IDX_W-1:0] NUM_SETIP = 6'd0;
  localparam logic [IDX_W-1:0] NUM_CLRIP = 6'd1;
  localparam logic [IDX_W-1:0] NUM_SETIE = 6'd2;
  localparam logic [IDX_W-1:0] NUM_CLRIE = 6'd3;

  localparam logic [2:0] MODE_OFF  = 3'd0;
  localparam logic [2:0] MODE_RISE = 3'd4;
  localparam logic [2:0] MODE_FALL = 3'd5;
  localparam logic [2:0] MODE_HIGH = 3'd6;
  localparam logic [2:0] MODE_LOW  = 3'd7;

  localparam int unsigned DELEG_BIT = 10;

  typedef struct packed {
    logic       deleg;
    logic [9:0] field;
  } src_cfg_t;

  function automatic src_cfg_t cfg_filter(input logic [10:0] w, input bit has_child);
    src_cfg_t c;
    c = '0;
    if (w[DELEG_BIT]) begin
      if (has_child) begin
        c.deleg = 1'b1;
        c.field = w[9:0];
      end
    end else begin
      c.field = {7'd0, w[2:0]};
    end
    return c;
  endfunction
endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
  import irq_src_pkg::*;
#(
  parameter bit HAS_CHILD = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       irq_i,
  input  logic       msg_mode_i,
  input  logic       cfg_we_i,
  input  logic [10:0] cfg_wdata_i,
  input  logic       set_ip_i,
  input  logic       clr_ip_i,
  input  logic       set_ie_i,
  input  logic       clr_ie_i,
  output src_cfg_t   cfg_o,
  output logic       ip_o,
  output logic       ie_o,
  output logic       cap_o
);
  src_cfg_t   cfg_q, cfg_d, cfg_new;
  logic       ip_q, ip_d, ie_q, ie_d, cap_q, cap_d;
  logic       hw_set, active, level, kill;
  logic [2:0] mode;

  always_comb begin
    mode   = cfg_q.field[2:0];
    active = !cfg_q.deleg && (mode != MODE_OFF);
    level  = (mode == MODE_HIGH) || (mode == MODE_LOW);
    hw_set = 1'b0;
    if (!cfg_q.deleg && !ip_q) begin
      case (mode)
        MODE_RISE: hw_set = irq_i && !cap_q;
        MODE_FALL: hw_set = !irq_i && cap_q;
        MODE_HIGH: hw_set = irq_i;
        MODE_LOW:  hw_set = !irq_i;
        default:   hw_set = 1'b0;
      endcase
    end
    cfg_new = cfg_filter(cfg_wdata_i, HAS_CHILD);
    kill    = cfg_new.deleg || (cfg_new.field == '0);

    // software ops act on top of the hardware decision
    ip_d = ip_q | hw_set;
    if (clr_ip_i && active && !level) ip_d = 1'b0;
    if (set_ip_i && active && (!level || msg_mode_i)) ip_d = 1'b1;
    ie_d = ie_q;
    if (set_ie_i && active) ie_d = 1'b1;
    if (clr_ie_i && active) ie_d = 1'b0;
    cfg_d = cfg_q;
    if (cfg_we_i) begin
      cfg_d = cfg_new;
      if (kill) begin
        ip_d = 1'b0;
        ie_d = 1'b0;
      end
    end
    cap_d = cfg_q.deleg ? cap_q : irq_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      ip_q  <= 1'b0;
      ie_q  <= 1'b0;
      cap_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      ip_q  <= ip_d;
      ie_q  <= ie_d;
      cap_q <= cap_d;
    end
  end

  assign cfg_o = cfg_q;
  assign ip_o  = ip_q;
  assign ie_o  = ie_q;
  assign cap_o = cap_q;
endmodule

// File: rtl/irq_src_regif.sv
module irq_src_regif
  import irq_src_pkg::*;
#(
  parameter int unsigned NUM_SRC = 31
) (
  input  logic                  we_i,
  input  logic [REG_AW-1:0]     addr_i,
  input  logic [31:0]           wdata_i,
  input  src_cfg_t [NUM_SRC:1]  cfg_i,
  input  logic [NUM_SRC:1]      ip_i,
  input  logic [NUM_SRC:1]      ie_i,
  input  logic [NUM_SRC:1]      cap_i,
  output logic [NUM_SRC:1]      cfg_we_o,
  output logic [NUM_SRC:1]      set_ip_o,
  output logic [NUM_SRC:1]      clr_ip_o,
  output logic [NUM_SRC:1]      set_ie_o,
  output logic [NUM_SRC:1]      clr_ie_o,
  output logic [31:0]           rdata_o
);
  localparam int unsigned NUM_WORDS = (NUM_SRC + 32) / 32;
  localparam int unsigned PAD_W     = NUM_WORDS * 32;

  logic [3:0]       region;
  logic [IDX_W-1:0] idx;
  logic [PAD_W-1:0] ip_pad, ie_pad, cap_pad;

  assign region = addr_i[REG_AW-1:IDX_W];
  assign idx    = addr_i[IDX_W-1:0];

  for (genvar s = 1; s <= NUM_SRC; s++) begin : g_dec
    localparam int unsigned WRD = s / 32;
    localparam int unsigned BIT = s % 32;
    logic num_hit, bm_bit;
    assign num_hit = we_i && (region == RG_NUM) && (wdata_i == 32'(s));
    assign bm_bit  = we_i && (idx == IDX_W'(WRD)) && wdata_i[BIT];
    assign cfg_we_o[s] = we_i && (region == RG_CFG) && (idx == IDX_W'(s - 1));
    assign set_ip_o[s] = (bm_bit && region == RG_SETIP) || (num_hit && idx == NUM_SETIP);
    assign clr_ip_o[s] = (bm_bit && region == RG_CLRIP) || (num_hit && idx == NUM_CLRIP);
    assign set_ie_o[s] = (bm_bit && region == RG_SETIE) || (num_hit && idx == NUM_SETIE);
    assign clr_ie_o[s] = (bm_bit && region == RG_CLRIE) || (num_hit && idx == NUM_CLRIE);
  end

  always_comb begin
    ip_pad  = '0;
    ie_pad  = '0;
    cap_pad = '0;
    ip_pad[NUM_SRC:1]  = ip_i;
    ie_pad[NUM_SRC:1]  = ie_i;
    cap_pad[NUM_SRC:1] = cap_i;
    rdata_o = '0;
    case (region)
      RG_CFG: begin
        for (int s = 1; s <= NUM_SRC; s++)
          if (idx == IDX_W'(s - 1)) rdata_o = {21'd0, cfg_i[s]};
      end
      RG_SETIP: begin
        for (int w = 0; w < NUM_WORDS; w++)
          if (idx == IDX_W'(w)) rdata_o = ip_pad[w*32 +: 32];
      end
      RG_CLRIP: begin
        for (int w = 0; w < NUM_WORDS; w++)
          if (idx == IDX_W'(w)) rdata_o = cap_pad[w*32 +: 32];
      end
      RG_SETIE: begin
        for (int w = 0; w < NUM_WORDS; w++)
          if (idx == IDX_W'(w)) rdata_o = ie_pad[w*32 +: 32];
      end
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import irq_src_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 31,
  parameter bit          HAS_CHILD = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 msg_mode_i,
  input  logic [NUM_SRC:1]     irq_i,
  input  logic                 reg_we_i,
  input  logic [REG_AW-1:0]    reg_addr_i,
  input  logic [31:0]          reg_wdata_i,
  output logic [31:0]          reg_rdata_o,
  output logic [NUM_SRC:1]     ip_en_o
);
  src_cfg_t [NUM_SRC:1]  cfg_v;
  logic [NUM_SRC:1]      ip_v, ie_v, cap_v, deleg_v;
  logic [NUM_SRC:1]      cfg_we_v, set_ip_v, clr_ip_v, set_ie_v, clr_ie_v;
  logic [NUM_SRC:1][2:0] mode_v;

  irq_src_regif #(.NUM_SRC(NUM_SRC)) i_regif (
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .cfg_i    (cfg_v),
    .ip_i     (ip_v),
    .ie_i     (ie_v),
    .cap_i    (cap_v),
    .cfg_we_o (cfg_we_v),
    .set_ip_o (set_ip_v),
    .clr_ip_o (clr_ip_v),
    .set_ie_o (set_ie_v),
    .clr_ie_o (clr_ie_v),
    .rdata_o  (reg_rdata_o)
  );

  for (genvar s = 1; s <= NUM_SRC; s++) begin : g_src
    irq_src_cell #(.HAS_CHILD(HAS_CHILD)) i_cell (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .irq_i       (irq_i[s]),
      .msg_mode_i  (msg_mode_i),
      .cfg_we_i    (cfg_we_v[s]),
      .cfg_wdata_i (reg_wdata_i[10:0]),
      .set_ip_i    (set_ip_v[s]),
      .clr_ip_i    (clr_ip_v[s]),
      .set_ie_i    (set_ie_v[s]),
      .clr_ie_i    (clr_ie_v[s]),
      .cfg_o       (cfg_v[s]),
      .ip_o        (ip_v[s]),
      .ie_o        (ie_v[s]),
      .cap_o       (cap_v[s])
    );
    assign ip_en_o[s] = ip_v[s] & ie_v[s];
    assign deleg_v[s] = cfg_v[s].deleg;
    assign mode_v[s]  = cfg_v[s].field[2:0];
  end
endmodule

// File: rtl/irq_src_bank_chk.sv
module irq_src_bank_chk
  import irq_src_pkg::*;
#(
  parameter int unsigned NUM_SRC = 31
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_SRC:1]     irq_i,
  input logic [NUM_SRC:1]     cfg_we_v,
  input logic [NUM_SRC:1]     clr_ip_v,
  input logic [3:0]           wkill_i,
  input logic [NUM_SRC:1]     deleg_v,
  input logic [NUM_SRC:1][2:0] mode_v,
  input logic [NUM_SRC:1]     ip_v,
  input logic [NUM_SRC:1]     ie_v,
  input logic [NUM_SRC:1]     cap_v
);
  logic wkill;
  assign wkill = wkill_i[3] || (wkill_i[2:0] == 3'd0);

  for (genvar s = 1; s <= NUM_SRC; s++) begin : g_chk
    logic lvl;
    assign lvl = (mode_v[s] == MODE_HIGH) || (mode_v[s] == MODE_LOW);

    AST_CFG_KILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_we_v[s] && wkill |=> !ip_v[s] && !ie_v[s]); // R3

    AST_RISE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !deleg_v[s] && mode_v[s] == MODE_RISE && irq_i[s] && !cap_v[s]
      && !clr_ip_v[s] && !cfg_we_v[s] |=> ip_v[s]); // R5

    AST_CAP_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !deleg_v[s] |=> cap_v[s] == $past(irq_i[s])); // R7

    AST_LVL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !deleg_v[s] && lvl && ip_v[s] && !cfg_we_v[s] |=> ip_v[s]); // R8

    AST_IE_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (deleg_v[s] || mode_v[s] == MODE_OFF) && !cfg_we_v[s] |=> $stable(ie_v[s])); // R9
  end
endmodule

bind irq_src_bank irq_src_bank_chk #(.NUM_SRC(NUM_SRC)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .irq_i    (irq_i),
  .cfg_we_v (cfg_we_v),
  .clr_ip_v (clr_ip_v),
  .wkill_i  ({reg_wdata_i[10], reg_wdata_i[2:0]}),
  .deleg_v  (deleg_v),
  .mode_v   (mode_v),
  .ip_v     (ip_v),
  .ie_v     (ie_v),
  .cap_v    (cap_v)
);

// File: tb/test_irq_src_bank.sv
`timescale 1ns/1ps
module test_irq_src_bank;
  localparam int NS = 31;
  localparam logic [3:0] T_CFG = 4'd0, T_SIP = 4'd1, T_CIP = 4'd2, T_SIE = 4'd3, T_CIE = 4'd4, T_NUM = 4'd5;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic msg_mode_i = 1'b0;
  logic [NS:1] irq_i = '0;
  logic reg_we_i = 1'b0;
  logic [9:0] reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o, solo_rdata;
  logic [NS:1] ip_en_o, solo_ip_en;

  always #2.5 clk_i = ~clk_i;

  irq_src_bank #(.NUM_SRC(NS), .HAS_CHILD(1'b1)) i_irq_src_bank (
    .clk_i, .rst_ni, .msg_mode_i, .irq_i, .reg_we_i, .reg_addr_i, .reg_wdata_i,
    .reg_rdata_o, .ip_en_o);
  irq_src_bank #(.NUM_SRC(NS), .HAS_CHILD(1'b0)) i_irq_src_bank_solo (
    .clk_i, .rst_ni, .msg_mode_i, .irq_i, .reg_we_i, .reg_addr_i, .reg_wdata_i,
    .reg_rdata_o(solo_rdata), .ip_en_o(solo_ip_en));

  int n_chk = 0, n_fail = 0;
  logic [10:0] m_cfg [1:NS];
  logic m_ip [1:NS], m_ie [1:NS], m_cap [1:NS];
  logic [NS:1] cur_irq = '0;
  logic cur_msg = 1'b0;

  function automatic logic [9:0] a_of(input logic [3:0] rg, input int ix);
    return {rg, 6'(ix)};
  endfunction

  function automatic logic [31:0] exp_read(input logic [9:0] a);
    logic [31:0] r;
    int ix;
    r = '0;
    ix = int'(a[5:0]);
    if (a[9:6] == T_CFG) begin
      if (ix < NS) r = {21'd0, m_cfg[ix + 1]};
    end else if (a[9:6] == T_SIP || a[9:6] == T_CIP || a[9:6] == T_SIE) begin
      for (int b = 0; b < 32; b++) begin
        int src;
        src = ix * 32 + b;
        if (src >= 1 && src <= NS)
          r[b] = (a[9:6] == T_SIP) ? m_ip[src] : (a[9:6] == T_CIP) ? m_cap[src] : m_ie[src];
      end
    end
    return r;
  endfunction

  function automatic logic [NS:1] exp_ipen();
    logic [NS:1] v;
    for (int s = 1; s <= NS; s++) v[s] = m_ip[s] & m_ie[s];
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [9:0] a, input logic [31:0] wd);
    logic [10:0] n_cfg [1:NS];
    logic n_ip [1:NS], n_ie [1:NS], n_cap [1:NS];
    reg_we_i = we; reg_addr_i = a; reg_wdata_i = wd;
    irq_i = cur_irq; msg_mode_i = cur_msg;
    for (int s = 1; s <= NS; s++) begin
      logic [2:0] md;
      logic dl, hw, act, lvl, sp, cp, se, ce, nh;
      md = m_cfg[s][2:0]; dl = m_cfg[s][10];
      hw = 1'b0;
      if (!dl && !m_ip[s])
        case (md)
          3'd4: hw = cur_irq[s] && !m_cap[s];
          3'd5: hw = !cur_irq[s] && m_cap[s];
          3'd6: hw = cur_irq[s];
          3'd7: hw = !cur_irq[s];
          default: hw = 1'b0;
        endcase
      n_ip[s] = m_ip[s] | hw; n_ie[s] = m_ie[s]; n_cfg[s] = m_cfg[s];
      n_cap[s] = dl ? m_cap[s] : cur_irq[s];
      act = !dl && md != 3'd0; lvl = md >= 3'd6;
      if (we) begin
        nh = (a[9:6] == T_NUM) && (wd == 32'(s));
        sp = (a[9:6] == T_SIP && int'(a[5:0]) == s / 32 && wd[s % 32]) || (nh && a[5:0] == 6'd0);
        cp = (a[9:6] == T_CIP && int'(a[5:0]) == s / 32 && wd[s % 32]) || (nh && a[5:0] == 6'd1);
        se = (a[9:6] == T_SIE && int'(a[5:0]) == s / 32 && wd[s % 32]) || (nh && a[5:0] == 6'd2);
        ce = (a[9:6] == T_CIE && int'(a[5:0]) == s / 32 && wd[s % 32]) || (nh && a[5:0] == 6'd3);
        if (cp && act && !lvl) n_ip[s] = 1'b0;
        if (sp && act && (!lvl || cur_msg)) n_ip[s] = 1'b1;
        if (se && act) n_ie[s] = 1'b1;
        if (ce && act) n_ie[s] = 1'b0;
        if (a[9:6] == T_CFG && int'(a[5:0]) == s - 1) begin
          n_cfg[s] = wd[10] ? {1'b1, wd[9:0]} : {8'd0, wd[2:0]};
          if (n_cfg[s][10] || n_cfg[s] == 11'd0) begin
            n_ip[s] = 1'b0; n_ie[s] = 1'b0;
          end
        end
      end
    end
    @(posedge clk_i);
    for (int s = 1; s <= NS; s++) begin
      m_cfg[s] = n_cfg[s]; m_ip[s] = n_ip[s]; m_ie[s] = n_ie[s]; m_cap[s] = n_cap[s];
    end
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd_chk(input logic [9:0] a, input logic [31:0] exp, input string tag);
    reg_we_i = 1'b0; reg_addr_i = a;
    #1;
    chk(reg_rdata_o === exp, tag, reg_rdata_o, exp);
  endtask

  task automatic bit_chk(input int s, input logic exp, input string tag);
    chk(ip_en_o[s] === exp, tag, 32'(ip_en_o[s]), 32'(exp));
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] snap;
    void'($urandom(32'd4242));
    for (int s = 1; s <= NS; s++) begin
      m_cfg[s] = '0; m_ip[s] = 1'b0; m_ie[s] = 1'b0; m_cap[s] = 1'b0;
    end
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(ip_en_o === '0, "R1 ip_en after reset", 32'(ip_en_o), 0);
    rd_chk(a_of(T_CFG, 0), 0, "R1 cfg read");
    rd_chk(a_of(T_SIP, 0), 0, "R1 pending read");
    rd_chk(a_of(T_CIP, 0), 0, "R1 captured read");
    rd_chk(a_of(T_SIE, 0), 0, "R1 enable read");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 masking, R4 no-children forcing
    step(1, a_of(T_CFG, 2), 32'hFFFF_FBFD);
    rd_chk(a_of(T_CFG, 2), 32'h0000_0005, "R2 mode-only mask");
    step(1, a_of(T_CFG, 2), 32'h0000_07AB);
    rd_chk(a_of(T_CFG, 2), 32'h0000_07AB, "R2 delegate mask");
    chk(solo_rdata === 32'd0, "R4 delegate forced to zero", solo_rdata, 0);
    step(1, a_of(T_CFG, 2), 32'h0);

    // R5 rising edge
    step(1, a_of(T_CFG, 4), 32'd4);
    step(1, a_of(T_NUM, 2), 32'd5);
    cur_irq[5] = 1'b1;
    step(0, 0, 0);
    bit_chk(5, 1'b1, "R5 rising sets pending");
    step(1, a_of(T_NUM, 1), 32'd5);
    bit_chk(5, 1'b0, "R5 software clear on edge source");
    step(0, 0, 0);
    bit_chk(5, 1'b0, "R5 held high gives no new edge");
    cur_irq[5] = 1'b0;
    // falling edge
    step(1, a_of(T_CFG, 5), 32'd5);
    step(1, a_of(T_SIE, 0), 32'h40);
    cur_irq[6] = 1'b1;
    step(0, 0, 0);
    bit_chk(6, 1'b0, "R5 falling ignores rise");
    cur_irq[6] = 1'b0;
    step(0, 0, 0);
    bit_chk(6, 1'b1, "R5 falling sets pending");
    step(1, a_of(T_CIE, 0), 32'h40);
    bit_chk(6, 1'b0, "R12 enable cleared masks output");
    rd_chk(a_of(T_SIP, 0), exp_read(a_of(T_SIP, 0)), "R12 pending still held");

    // R6 / R8 level sources
    step(1, a_of(T_CFG, 6), 32'd6);
    step(1, a_of(T_NUM, 2), 32'd7);
    cur_irq[7] = 1'b1;
    step(0, 0, 0);
    bit_chk(7, 1'b1, "R6 level high sets pending");
    cur_irq[7] = 1'b0;
    step(1, a_of(T_CIP, 0), 32'h80);
    bit_chk(7, 1'b1, "R8 direct level clear ignored");
    cur_msg = 1'b1;
    step(1, a_of(T_NUM, 1), 32'd7);
    bit_chk(7, 1'b1, "R8 message level clear ignored");
    step(1, a_of(T_CFG, 6), 32'd6);
    bit_chk(7, 1'b1, "R3 nonzero config keeps pending");
    step(1, a_of(T_CFG, 6), 32'd0);
    bit_chk(7, 1'b0, "R3 zero config clears");
    rd_chk(a_of(T_SIE, 0), exp_read(a_of(T_SIE, 0)), "R3 enable cleared");
    step(1, a_of(T_CFG, 7), 32'd7);
    step(1, a_of(T_NUM, 2), 32'd8);
    bit_chk(8, 1'b1, "R6 level low sets pending");
    step(1, a_of(T_CFG, 8), 32'd6);
    step(1, a_of(T_NUM, 2), 32'd9);
    step(1, a_of(T_NUM, 0), 32'd9);
    bit_chk(9, 1'b1, "R8 message level set applied");
    cur_msg = 1'b0;
    step(1, a_of(T_CFG, 9), 32'd6);
    step(1, a_of(T_NUM, 2), 32'd10);
    step(1, a_of(T_NUM, 0), 32'd10);
    bit_chk(10, 1'b0, "R8 direct level set ignored");

    // R9 / R8 inactive and delegated sources
    step(1, a_of(T_NUM, 2), 32'd11);
    rd_chk(a_of(T_SIE, 0), exp_read(a_of(T_SIE, 0)), "R9 inactive enable");
    chk(reg_rdata_o[11] === 1'b0, "R9 inactive enable bit", 32'(reg_rdata_o[11]), 0);
    step(1, a_of(T_CFG, 11), 32'h401);
    step(1, a_of(T_NUM, 2), 32'd12);
    rd_chk(a_of(T_SIE, 0), exp_read(a_of(T_SIE, 0)), "R9 delegated enable");
    chk(reg_rdata_o[12] === 1'b0, "R9 delegated enable bit", 32'(reg_rdata_o[12]), 0);
    step(1, a_of(T_NUM, 0), 32'd12);
    step(1, a_of(T_NUM, 0), 32'd11);
    rd_chk(a_of(T_SIP, 0), exp_read(a_of(T_SIP, 0)), "R8 inactive/delegated set");
    chk(reg_rdata_o[12:11] === 2'b00, "R8 inactive/delegated pending bits", 32'(reg_rdata_o[12:11]), 0);

    // R10 bitmap corners
    step(1, a_of(T_SIP, 0), 32'h1);
    rd_chk(a_of(T_SIP, 0), exp_read(a_of(T_SIP, 0)), "R10 source0 write");
    chk(reg_rdata_o[0] === 1'b0, "R10 source0 bit", 32'(reg_rdata_o[0]), 0);
    rd_chk(a_of(T_CIE, 0), 0, "R10 clear-enable reads zero");
    rd_chk(a_of(T_SIP, 1), 0, "R10 word beyond range");

    // R7 captured levels
    cur_irq = 31'h52A5_5A5A;
    step(0, 0, 0);
    rd_chk(a_of(T_CIP, 0), exp_read(a_of(T_CIP, 0)), "R7 captured levels");
    cur_irq = '0;
    step(0, 0, 0);
    step(0, 0, 0);

    // R11 number corners
    reg_addr_i = a_of(T_SIP, 0);
    #1 snap = reg_rdata_o;
    step(1, a_of(T_NUM, 0), 32'd0);
    step(1, a_of(T_NUM, 0), 32'd32);
    rd_chk(a_of(T_SIP, 0), snap, "R11 out-of-range numbers ignored");

    // random phase, R12 / R10 against model
    for (int i = 0; i < 3000; i++) begin
      logic we;
      logic [9:0] a;
      logic [31:0] wd;
      if (i % 500 == 0) cur_msg = $urandom_range(1, 0) == 1;
      cur_irq = NS'($urandom);
      we = ($urandom_range(3, 0) == 0);
      a = '0; wd = '0;
      if (we) begin
        case ($urandom_range(5, 0))
          0: begin
            a = a_of(T_CFG, $urandom_range(31, 0));
            case ($urandom_range(7, 0))
              0: wd = 0; 1: wd = 1; 2: wd = 4; 3: wd = 5; 4: wd = 6; 5: wd = 7;
              6: wd = 32'h400 | ($urandom & 32'h3FF);
              default: wd = $urandom;
            endcase
          end
          1, 2, 3, 4: begin
            a = a_of(4'($urandom_range(4, 1)), $urandom_range(1, 0));
            wd = $urandom;
          end
          default: begin
            a = a_of(T_NUM, $urandom_range(3, 0));
            wd = $urandom_range(33, 0);
          end
        endcase
      end
      step(we, a, wd);
      chk(ip_en_o === exp_ipen(), "R12 random ip_en", 32'(ip_en_o), 32'(exp_ipen()));
      a = a_of(4'($urandom_range(6, 0)), $urandom_range(33, 0));
      rd_chk(a, exp_read(a), "R10 random read");
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule